// File: doc/BRIEF.md
# Isochronous Transmit Context Control Bank

This block holds the control and status word for each of eight isochronous transmit DMA contexts. Software changes a word through two write addresses per context. A write to the first address turns on every bit that is 1 in the data. A write to the second address turns off every bit that is 1 in the data. Either address reads back the same word. The DMA engine reports descriptor fetches, fatal errors, busy state and completion codes on per-context strobes, and those reports update the status bits directly.

Each context can hold its first packet back until a chosen isochronous cycle. The cycle is named by a 15-bit value: the low two bits of the cycle timer's seconds, followed by its 13-bit cycle count. The block compares this value against the timer at each cycle-start strobe. It drives a per-context enable (running and not failed) and a start output that tells the engine it may transmit.

Top module: `iso_tx_ctx_bank`

## Requirements
- R1: After a synchronous reset, every bit of every context word reads 0, and `ctx_enable` and `ctx_start` are all 0.
- R2: Context n (0 to 7) has its set address at 0x200 + 16·n and its clear address at 0x204 + 16·n. A write to the set address turns on the data's 1 bits. A write to the clear address turns off the data's 1 bits. Either address reads the word combinationally. Any other address reads 0.
- R3: The run flag (bit 15) changes only through software writes. `ctx_enable[n]` is 1 exactly when run is 1 and dead is 0.
- R4: The wake flag (bit 12) is turned on by the set address. The clear address has no effect on it. A `dma_fetch[n]` pulse turns it off, and the pulse wins over a set write in the same cycle.
- R5: The dead flag (bit 11) is turned on by `dma_fatal[n]`. It is turned off by a clear-address write that has bit 15 at 1. A fatal pulse in the same cycle wins, so dead stays 1.
- R6: The active flag (bit 10) is 1 in the cycle after a clock edge at which `dma_busy[n]` was 1 and run was 1 after that edge. Otherwise it is 0, and it goes to 0 at the edge where run is turned off.
- R7: The cycle-match enable (bit 31) is turned off by hardware at the edge where active becomes 1. This takes priority over a set write in the same cycle.
- R8: On `dma_done[n]`, bits 4:0 take `dma_evt`. The code is kept only if it is 0x11, 0x06, 0x07 or 0x0E; any other code is stored as 0x0E. Software writes to bits 4:0 have no effect.
- R9: Bits 14:13 and 9:5 always read 0, whatever is written.
- R10: `ctx_start[n]` is 1 in the same cycle when run is 1 and dead is 0, and either cycle-match enable is 0, or `cyc_start` is 1 and {`cyc_secs_lo`, `cyc_count`} equals bits 30:16.
- R11: The 15-bit cycle-match value in bits 30:16 is turned on and off bit by bit through the set and clear addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 12 | Byte address of register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| dma_fetch | input | 8 | Per-context descriptor fetch pulse |
| dma_fatal | input | 8 | Per-context fatal error pulse |
| dma_busy | input | 8 | Per-context descriptor processing level |
| dma_done | input | 8 | Per-context completion pulse |
| dma_evt | input | 5 | Completion code sampled with dma_done |
| cyc_secs_lo | input | 2 | Low two bits of the cycle timer seconds |
| cyc_count | input | 13 | Cycle timer cycle count |
| cyc_start | input | 1 | Cycle-start strobe |
| ctx_enable | output | 8 | Context running and not dead |
| ctx_start | output | 8 | Context may transmit now |

## Verification
Writes and DMA strobes change the stored bits at the next rising edge. From that edge on, the change shows on `reg_rdata` and `ctx_enable`. `ctx_start` reacts to `cyc_start` and the timer in the same cycle, because that path has no register. The bench holds each stimulus from one falling edge through the next rising edge. It compares the outputs against its model 1 ns after the falling edge, and it advances its model state at each rising edge, so a result due one edge later is checked exactly in the following cycle.

// File: rtl/iso_ctl_pkg.sv
package iso_ctl_pkg;

    localparam int WORD_W  = 32;
    localparam int MATCH_W = 15;
    localparam int CODE_W  = 5;

    localparam int BIT_MEN  = 31;
    localparam int BIT_RUN  = 15;
    localparam int BIT_WAKE = 12;
    localparam int BIT_DEAD = 11;
    localparam int BIT_ACT  = 10;

    localparam logic [WORD_W-1:0] RSVD_MASK = 32'h0000_63E0;

    typedef enum logic [CODE_W-1:0] {
        EV_NONE    = 5'h00,
        EV_DESC_RD = 5'h06,
        EV_DATA_RD = 5'h07,
        EV_UNKNOWN = 5'h0E,
        EV_ACK_OK  = 5'h11
    } evcode_e;

    // stored state of one context
    typedef struct packed {
        logic               match_en;
        logic [MATCH_W-1:0] match;
        logic               run;
        logic               wake;
        logic               dead;
        logic               active;
        logic [CODE_W-1:0]  code;
    } ctx_state_t;

    // the software-writable subset of a write word
    typedef struct packed {
        logic               match_en;
        logic [MATCH_W-1:0] match;
        logic               run;
        logic               wake;
    } sw_bits_t;

    function automatic sw_bits_t take_bits(input logic [WORD_W-1:0] w);
        sw_bits_t b;
        b.match_en = w[BIT_MEN];
        b.match    = w[30:16];
        b.run      = w[BIT_RUN];
        b.wake     = w[BIT_WAKE];
        return b;
    endfunction

    function automatic logic [CODE_W-1:0] legal_code(input logic [CODE_W-1:0] c);
        case (c)
            EV_ACK_OK, EV_DESC_RD, EV_DATA_RD, EV_UNKNOWN: return c;
            default: return EV_UNKNOWN;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input ctx_state_t s);
        logic [WORD_W-1:0] w;
        w           = '0;
        w[BIT_MEN]  = s.match_en;
        w[30:16]    = s.match;
        w[BIT_RUN]  = s.run;
        w[BIT_WAKE] = s.wake;
        w[BIT_DEAD] = s.dead;
        w[BIT_ACT]  = s.active;
        w[4:0]      = s.code;
        return w;
    endfunction

endpackage

// File: rtl/iso_ctl_dec.sv
module iso_ctl_dec #(
    parameter int NCTX   = 8,
    parameter int AW     = 12,
    parameter int BASE   = 'h200,
    parameter int STRIDE = 16,
    localparam int CW    = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic [AW-1:0]   addr,
    input  logic            we,
    output logic [NCTX-1:0] set_hit,
    output logic [NCTX-1:0] clr_hit,
    output logic [CW-1:0]   rd_sel,
    output logic            rd_hit
);

    logic [NCTX-1:0] sel_hit;

    for (genvar n = 0; n < NCTX; n++) begin : g_ctx
        localparam logic [AW-1:0] SET_A = AW'(BASE + n * STRIDE);
        localparam logic [AW-1:0] CLR_A = AW'(BASE + n * STRIDE + 4);
        assign set_hit[n] = we && (addr == SET_A);
        assign clr_hit[n] = we && (addr == CLR_A);
        assign sel_hit[n] = (addr == SET_A) || (addr == CLR_A);
    end

    always_comb begin
        rd_sel = '0;
        for (int n = 0; n < NCTX; n++) begin
            if (sel_hit[n]) rd_sel = CW'(n);
        end
    end

    assign rd_hit = |sel_hit;

endmodule

// File: rtl/iso_ctl_ctx.sv
module iso_ctl_ctx
    import iso_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sw_set,
    input  logic               sw_clr,
    input  sw_bits_t           sw_bits,
    input  logic               fetch,
    input  logic               fatal,
    input  logic               busy,
    input  logic               done,
    input  logic [CODE_W-1:0]  evt,
    input  logic               cyc_start,
    input  logic [MATCH_W-1:0] cyc_now,
    output ctx_state_t         st,
    output logic               enable,
    output logic               start
);

    ctx_state_t nxt;

    always_comb begin
        nxt = st;
        if (sw_set) begin
            nxt.match_en = st.match_en | sw_bits.match_en;
            nxt.match    = st.match | sw_bits.match;
            nxt.run      = st.run | sw_bits.run;
            nxt.wake     = st.wake | sw_bits.wake;
        end
        if (sw_clr) begin
            nxt.match_en = st.match_en & ~sw_bits.match_en;
            nxt.match    = st.match & ~sw_bits.match;
            nxt.run      = st.run & ~sw_bits.run;
            if (sw_bits.run) nxt.dead = 1'b0;
        end
        // hardware updates override software on the same bit
        if (fetch) nxt.wake = 1'b0;
        if (fatal) nxt.dead = 1'b1;
        nxt.active = nxt.run & busy;
        if (nxt.active) nxt.match_en = 1'b0;
        if (done) nxt.code = legal_code(evt);
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nxt;
    end

    assign enable = st.run & ~st.dead;
    assign start  = enable & (~st.match_en | (cyc_start & (cyc_now == st.match)));

    AST_FETCH_CLEARS_WAKE: assert property (@(posedge clk) disable iff (rst)
        fetch |=> !st.wake); // R4
    AST_FATAL_SETS_DEAD: assert property (@(posedge clk) disable iff (rst)
        fatal |=> st.dead); // R5
    AST_IDLE_NOT_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !st.active); // R6
    AST_ACTIVE_DROPS_MATCH: assert property (@(posedge clk) disable iff (rst)
        $rose(st.active) |-> !st.match_en); // R7
    AST_ACK_CODE_KEPT: assert property (@(posedge clk) disable iff (rst)
        (done && evt == EV_ACK_OK) |=> st.code == EV_ACK_OK); // R8
    AST_RUN_SW_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!sw_set && !sw_clr) |=> $stable(st.run)); // R3
    AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
        start |-> (st.run && !st.dead)); // R10

endmodule

// File: rtl/iso_ctl_rdmux.sv
module iso_ctl_rdmux
    import iso_ctl_pkg::*;
#(
    parameter int NCTX = 8,
    localparam int CW  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  ctx_state_t        st [NCTX],
    input  logic [CW-1:0]     rd_sel,
    input  logic              rd_hit,
    output logic [WORD_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (rd_hit) rdata = pack_word(st[rd_sel]);
    end

endmodule

// File: rtl/iso_tx_ctx_bank.sv
module iso_tx_ctx_bank
    import iso_ctl_pkg::*;
#(
    parameter int NCTX   = 8,
    parameter int AW     = 12,
    parameter int BASE   = 'h200,
    parameter int STRIDE = 16,
    localparam int CW    = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [AW-1:0]      reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    input  logic               reg_we,
    output logic [WORD_W-1:0]  reg_rdata,
    input  logic [NCTX-1:0]    dma_fetch,
    input  logic [NCTX-1:0]    dma_fatal,
    input  logic [NCTX-1:0]    dma_busy,
    input  logic [NCTX-1:0]    dma_done,
    input  logic [CODE_W-1:0]  dma_evt,
    input  logic [1:0]         cyc_secs_lo,
    input  logic [12:0]        cyc_count,
    input  logic               cyc_start,
    output logic [NCTX-1:0]    ctx_enable,
    output logic [NCTX-1:0]    ctx_start
);

    logic [NCTX-1:0]    set_hit;
    logic [NCTX-1:0]    clr_hit;
    logic [CW-1:0]      rd_sel;
    logic               rd_hit;
    ctx_state_t         st [NCTX];
    sw_bits_t           sw_bits;
    logic [MATCH_W-1:0] cyc_now;
    logic               unused_wbits;

    assign sw_bits      = take_bits(reg_wdata);
    assign cyc_now      = {cyc_secs_lo, cyc_count};
    assign unused_wbits = ^{reg_wdata[14:13], reg_wdata[11:0]};

    iso_ctl_dec #(
        .NCTX(NCTX), .AW(AW), .BASE(BASE), .STRIDE(STRIDE)
    ) u_dec (
        .addr(reg_addr), .we(reg_we),
        .set_hit(set_hit), .clr_hit(clr_hit),
        .rd_sel(rd_sel), .rd_hit(rd_hit)
    );

    for (genvar n = 0; n < NCTX; n++) begin : g_ctx
        iso_ctl_ctx u_ctx (
            .clk(clk), .rst(rst),
            .sw_set(set_hit[n]), .sw_clr(clr_hit[n]), .sw_bits(sw_bits),
            .fetch(dma_fetch[n]), .fatal(dma_fatal[n]),
            .busy(dma_busy[n]), .done(dma_done[n]), .evt(dma_evt),
            .cyc_start(cyc_start), .cyc_now(cyc_now),
            .st(st[n]), .enable(ctx_enable[n]), .start(ctx_start[n])
        );
    end

    iso_ctl_rdmux #(.NCTX(NCTX)) u_rd (
        .st(st), .rd_sel(rd_sel), .rd_hit(rd_hit), .rdata(reg_rdata)
    );

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & RSVD_MASK) == '0); // R9
    AST_DEAD_BLOCKS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (dma_fatal != '0) |=> ((ctx_enable & dma_fatal) == '0)); // R3

endmodule

// File: tb/sim_iso_tx_ctx_bank.sv
`timescale 1ns/1ps
module sim_iso_tx_ctx_bank;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic        reg_we;
    logic [31:0] reg_rdata;
    logic [7:0]  dma_fetch, dma_fatal, dma_busy, dma_done;
    logic [4:0]  dma_evt;
    logic [1:0]  cyc_secs_lo;
    logic [12:0] cyc_count;
    logic        cyc_start;
    logic [7:0]  ctx_enable, ctx_start;

    always #4 clk = ~clk;

    iso_tx_ctx_bank u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata),
        .dma_fetch(dma_fetch), .dma_fatal(dma_fatal), .dma_busy(dma_busy),
        .dma_done(dma_done), .dma_evt(dma_evt),
        .cyc_secs_lo(cyc_secs_lo), .cyc_count(cyc_count), .cyc_start(cyc_start),
        .ctx_enable(ctx_enable), .ctx_start(ctx_start)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;
    string cur_req = "R1";

    // behavioural model state
    bit          m_run[8], m_cme[8], m_wake[8], m_dead[8], m_act[8];
    logic [14:0] m_mat[8];
    logic [4:0]  m_ev[8];

    function automatic logic [4:0] fix_code(input logic [4:0] c);
        if (c == 5'h11 || c == 5'h06 || c == 5'h07 || c == 5'h0E) return c;
        return 5'h0E;
    endfunction

    function automatic logic [31:0] m_word(input int n);
        logic [31:0] w;
        w = '0;
        w[31] = m_cme[n]; w[30:16] = m_mat[n]; w[15] = m_run[n];
        w[12] = m_wake[n]; w[11] = m_dead[n]; w[10] = m_act[n]; w[4:0] = m_ev[n];
        return w;
    endfunction

    function automatic logic [31:0] m_read();
        int a = int'(reg_addr);
        if (a >= 'h200 && a < 'h280 && (a % 16 == 0 || a % 16 == 4))
            return m_word((a - 'h200) / 16);
        return '0;
    endfunction

    function automatic logic [7:0] m_en();
        logic [7:0] v;
        for (int n = 0; n < 8; n++) v[n] = m_run[n] && !m_dead[n];
        return v;
    endfunction

    function automatic logic [7:0] m_start();
        logic [7:0] v;
        for (int n = 0; n < 8; n++)
            v[n] = m_run[n] && !m_dead[n] &&
                   (!m_cme[n] || (cyc_start && {cyc_secs_lo, cyc_count} == m_mat[n]));
        return v;
    endfunction

    task automatic model_step();
        for (int n = 0; n < 8; n++) begin
            if (rst) begin
                m_run[n] = 0; m_cme[n] = 0; m_wake[n] = 0; m_dead[n] = 0;
                m_act[n] = 0; m_mat[n] = '0; m_ev[n] = '0;
            end else begin
                bit s = reg_we && (int'(reg_addr) == 'h200 + 16 * n);
                bit c = reg_we && (int'(reg_addr) == 'h204 + 16 * n);
                if (s) begin
                    if (reg_wdata[31]) m_cme[n] = 1;
                    m_mat[n] = m_mat[n] | reg_wdata[30:16];
                    if (reg_wdata[15]) m_run[n] = 1;
                    if (reg_wdata[12]) m_wake[n] = 1;
                end
                if (c) begin
                    if (reg_wdata[31]) m_cme[n] = 0;
                    m_mat[n] = m_mat[n] & ~reg_wdata[30:16];
                    if (reg_wdata[15]) begin m_run[n] = 0; m_dead[n] = 0; end
                end
                if (dma_fetch[n]) m_wake[n] = 0;
                if (dma_fatal[n]) m_dead[n] = 1;
                m_act[n] = m_run[n] && dma_busy[n];
                if (m_act[n]) m_cme[n] = 0;
                if (dma_done[n]) m_ev[n] = fix_code(dma_evt);
            end
        end
    endtask

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    // compare, advance one edge, return to falling edge
    task automatic tick();
        #1;
        check("rdata", reg_rdata, m_read());
        check("enable", {24'h0, ctx_enable}, {24'h0, m_en()});
        check("start", {24'h0, ctx_start}, {24'h0, m_start()});
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_addr = 12'(a); reg_wdata = d; reg_we = 1'b1;
        tick();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic look(input int a, input int cycles);
        reg_addr = 12'(a);
        for (int i = 0; i < cycles; i++) tick();
    endtask

    function automatic int sa(input int n); return 'h200 + 16 * n; endfunction
    function automatic int ca(input int n); return 'h204 + 16 * n; endfunction

    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_addr = 12'h200; reg_wdata = '0; reg_we = 1'b0;
        dma_fetch = '0; dma_fatal = '0; dma_busy = '0; dma_done = '0; dma_evt = '0;
        cyc_secs_lo = '0; cyc_count = '0; cyc_start = 1'b0;
        for (int n = 0; n < 8; n++) begin
            m_run[n] = 0; m_cme[n] = 0; m_wake[n] = 0; m_dead[n] = 0;
            m_act[n] = 0; m_mat[n] = '0; m_ev[n] = '0;
        end
        repeat (2) @(posedge clk);
        @(negedge clk);

        cur_req = "R1";
        look(sa(0), 2);
        rst = 1'b0;
        for (int n = 0; n < 8; n++) look(ca(n), 1);

        cur_req = "R2";
        wr(sa(3), 32'h0000_8000);
        look(sa(3), 1); look(ca(3), 1);
        look('h208, 1); look('h300, 1); look('h1F0, 1); look('h23C, 1);

        cur_req = "R3";
        for (int n = 0; n < 8; n++) wr(sa(n), 32'h0000_8000);
        look(sa(0), 1);
        wr(ca(3), 32'h0000_8000); wr(ca(5), 32'h0000_8000);
        look(sa(3), 3);

        cur_req = "R11";
        wr(sa(2), 32'h1234_0000);
        look(sa(2), 1);
        wr(ca(2), 32'h0230_0000);
        wr(sa(2), 32'h4001_0000);
        look(ca(2), 1);

        cur_req = "R9";
        wr(sa(5), 32'hFFFF_FFFF);
        look(sa(5), 2);
        wr(ca(5), 32'hFFFF_FFFF);
        look(sa(5), 2);

        cur_req = "R4";
        wr(sa(1), 32'h0000_1000);
        wr(ca(1), 32'h0000_1000);
        look(sa(1), 1);
        dma_fetch = 8'h02; look(sa(1), 1); dma_fetch = '0;
        look(sa(1), 1);
        dma_fetch = 8'h02; wr(sa(1), 32'h0000_1000); dma_fetch = '0;
        look(sa(1), 2);

        cur_req = "R5";
        wr(sa(4), 32'h0000_8000);
        dma_fatal = 8'h10; look(sa(4), 1); dma_fatal = '0;
        look(sa(4), 2);
        dma_fatal = 8'h10; wr(ca(4), 32'h0000_8000); dma_fatal = '0;
        look(sa(4), 1);
        wr(ca(4), 32'h0000_8000);
        look(sa(4), 1);

        cur_req = "R6";
        wr(sa(6), 32'h0000_8000);
        dma_busy = 8'h40; look(sa(6), 3);
        wr(ca(6), 32'h0000_8000);
        look(sa(6), 2);
        dma_busy = '0; look(sa(6), 1);

        cur_req = "R7";
        wr(sa(7), 32'h8000_8000 | (32'h0ABC << 16));
        look(sa(7), 1);
        dma_busy = 8'h80; look(sa(7), 1);
        wr(sa(7), 32'h8000_0000);
        look(sa(7), 1);
        dma_busy = '0; look(sa(7), 1);
        wr(sa(7), 32'h8000_0000);
        look(sa(7), 1);

        cur_req = "R8";
        dma_done = 8'h01;
        dma_evt = 5'h11; look(sa(0), 1);
        dma_evt = 5'h06; look(sa(0), 1);
        dma_evt = 5'h07; look(sa(0), 1);
        dma_evt = 5'h0E; look(sa(0), 1);
        dma_evt = 5'h11; look(sa(0), 1);
        dma_evt = 5'h03; look(sa(0), 1);
        dma_done = '0; dma_evt = '0;
        wr(sa(0), 32'h0000_001F);
        wr(ca(0), 32'h0000_001F);
        look(sa(0), 1);

        cur_req = "R10";
        wr(ca(2), 32'hFFFF_FFFF);
        wr(sa(2), 32'h8000_8000 | (32'h6ABC << 16));
        cyc_secs_lo = 2'b11; cyc_count = 13'h0ABC; look(sa(2), 1);
        cyc_start = 1'b1; look(sa(2), 1);
        cyc_secs_lo = 2'b10; look(sa(2), 1);
        cyc_secs_lo = 2'b11; cyc_count = 13'h0ABD; look(sa(2), 1);
        cyc_count = 13'h0ABC; look(sa(2), 1);
        cyc_start = 1'b0; look(sa(2), 1);
        dma_fatal = 8'h04; look(sa(2), 1); dma_fatal = '0;
        cyc_start = 1'b1; look(sa(2), 1);
        cyc_start = 1'b0;
        wr(ca(2), 32'h0000_8000);
        wr(sa(2), 32'h0000_8000);
        dma_busy = 8'h04; look(sa(2), 2); dma_busy = '0;
        look(sa(2), 2);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule